// File: doc/BRIEF.md
# Dual Transmit/Receive Word Queue with Occupancy Status

This block holds two independent first-in first-out queues of 9-bit words sitting between a register port and a serial shifter. The transmit queue is filled by register writes and drained by the serial engine one word per strobe. The receive queue is filled by the serial engine with every word it shifts in, including the address word echoed back at the start of a read. Register reads drain it. Each queue has its own enable. A single soft-reset strobe empties both.

Each side reports a narrow occupancy field that is only as wide as the queue's address. A queue holding all of its entries therefore shows a level of zero, and a separate flag must be used to tell full from empty. On the transmit side this is the full flag. On the receive side it is the ready flag. Both sides report half-full and sticky overflow and underflow bits. The block also raises an error flag when a soft reset discards unread receive words.

Top module: `dual_fifo_status`

## Requirements
- R1: After the synchronous reset `rst`, both levels are 0 and every flag (half, full/ready, overflow, underflow, flush error) is 0.
- R2: The level output equals the occupancy modulo DEPTH (a 3-bit field for DEPTH 8). With all 8 entries held, the level reads 0 and `tx_full`/`rx_ready` is 1. That flag is 0 at every other occupancy.
- R3: Words leave a queue in the order they entered, with all 9 bits intact. The read-data output shows the popped word on the clock edge that accepts the pop strobe.
- R4: The half flag is 1 exactly when the occupancy is 4 or more.
- R5: A push into a full queue is dropped and sets that side's sticky overflow bit. The stored words and the occupancy are unchanged.
- R6: A pop from an empty queue leaves the read-data output holding the last word it showed. It sets that side's sticky underflow bit, and the occupancy stays 0.
- R7: A push and a pop in the same cycle on a queue that is neither empty nor full leave the occupancy unchanged. The oldest word is returned.
- R8: While a side's enable is 0, its push and pop strobes have no effect on its level, its data or its flags.
- R9: A `soft_rst` strobe empties both queues and clears their overflow and underflow bits. It overrides any push or pop in the same cycle.
- R10: On a `soft_rst` strobe, `flush_busy_err` becomes 1 if the receive queue held any words, including the full case where the level reads 0. It becomes 0 if the receive queue was empty.
- R11: The receive queue keeps every word pushed into it, the first (echoed address) word included. Activity on one side never changes the other side's level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Flush strobe for both queues |
| tx_fifo_en | input | 1 | Transmit queue enable |
| rx_fifo_en | input | 1 | Receive queue enable |
| tx_wr | input | 1 | Register write pushes `tx_wdata` |
| tx_wdata | input | 9 | Word to transmit |
| tx_take | input | 1 | Serial engine pops a transmit word |
| tx_word | output | 9 | Word handed to the serial engine |
| rx_put | input | 1 | Serial engine pushes `rx_word` |
| rx_word | input | 9 | Word shifted in |
| rx_rd | input | 1 | Register read pops a receive word |
| rx_rdata | output | 9 | Word returned to the register read |
| tx_level | output | 3 | Transmit occupancy modulo 8 |
| tx_half | output | 1 | Transmit occupancy at least 4 |
| tx_full | output | 1 | Transmit queue holds 8 words |
| tx_ovf | output | 1 | Sticky transmit overflow |
| tx_unf | output | 1 | Sticky transmit underflow |
| rx_level | output | 3 | Receive occupancy modulo 8 |
| rx_half | output | 1 | Receive occupancy at least 4 |
| rx_ready | output | 1 | Receive queue holds 8 words |
| rx_ovf | output | 1 | Sticky receive overflow |
| rx_unf | output | 1 | Sticky receive underflow |
| flush_busy_err | output | 1 | Last soft reset discarded receive words |

## Verification
On every cycle the assertions check several occupancy rules: the count stays in range, a flush empties the queue and clears its stickies, and a disabled queue keeps its count. They also check that a dropped push or empty pop leaves the count and data where they were, and that a balanced push and pop keep the count. A flush of a non-empty receive queue must raise the error. Only the bench scenarios can show word ordering and data integrity across the full sweep of fill depths. They also show the wrapped level field next to the full and ready flags, independence between the two sides, and the error clearing on a clean flush.

// File: rtl/dfifo_pkg.sv
package dfifo_pkg;
  localparam int unsigned DFIFO_WIDTH = 9;
  localparam int unsigned DFIFO_DEPTH = 8;
endpackage

// File: rtl/dfifo_core.sv
module dfifo_core #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic [AW-1:0]    level,
  output logic             full,
  output logic             half,
  output logic             ovf,
  output logic             unf
);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_HALF = CW'(DEPTH / 2);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt;
  logic             is_full, is_empty, do_push, do_pop;

  assign is_full  = (cnt == CNT_FULL);
  assign is_empty = (cnt == '0);
  assign do_push  = en && push && !is_full && !flush;
  assign do_pop   = en && pop && !is_empty && !flush;

  // storage: no reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)         pop_data <= '0;
    else if (do_pop) pop_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      ovf  <= 1'b0;
      unf  <= 1'b0;
    end else begin
      if (do_push) wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
      if (en && push && is_full) ovf <= 1'b1;
      if (en && pop && is_empty) unf <= 1'b1;
    end
  end

  assign level = cnt[AW-1:0];
  assign full  = is_full;
  assign half  = (cnt >= CNT_HALF);

  assert_count_range_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_FULL);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (en && !flush && push && !pop && is_full) |=> (cnt == CNT_FULL && ovf));

  assert_empty_pop_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (en && !flush && pop && !push && is_empty) |=> (cnt == '0 && unf && $stable(pop_data)));

  assert_balanced_R7: assert property (@(posedge clk) disable iff (rst)
    (en && !flush && push && pop && !is_empty && !is_full) |=> $stable(cnt));

  assert_disabled_R8: assert property (@(posedge clk) disable iff (rst)
    (!en && !flush) |=> ($stable(cnt) && $stable(pop_data)));

  assert_flush_R9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (cnt == '0 && !ovf && !unf));
endmodule

// File: rtl/dfifo_flush_guard.sv
module dfifo_flush_guard #(
  parameter int unsigned LW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [LW-1:0] rx_level,
  input  logic          rx_full,
  output logic          busy_err
);
  logic rx_holds;
  assign rx_holds = (rx_level != '0) || rx_full;

  always_ff @(posedge clk) begin
    if (rst)        busy_err <= 1'b0;
    else if (flush) busy_err <= rx_holds;
  end

  assert_busy_err_R10: assert property (@(posedge clk) disable iff (rst)
    (flush && rx_holds) |=> busy_err);

  assert_busy_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (flush && !rx_holds) |=> !busy_err);
endmodule

// File: rtl/dual_fifo_status.sv
module dual_fifo_status
  import dfifo_pkg::*;
#(
  parameter int unsigned WIDTH = DFIFO_WIDTH,
  parameter int unsigned DEPTH = DFIFO_DEPTH,
  localparam int unsigned LW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             tx_fifo_en,
  input  logic             rx_fifo_en,
  input  logic             tx_wr,
  input  logic [WIDTH-1:0] tx_wdata,
  input  logic             tx_take,
  output logic [WIDTH-1:0] tx_word,
  input  logic             rx_put,
  input  logic [WIDTH-1:0] rx_word,
  input  logic             rx_rd,
  output logic [WIDTH-1:0] rx_rdata,
  output logic [LW-1:0]    tx_level,
  output logic             tx_half,
  output logic             tx_full,
  output logic             tx_ovf,
  output logic             tx_unf,
  output logic [LW-1:0]    rx_level,
  output logic             rx_half,
  output logic             rx_ready,
  output logic             rx_ovf,
  output logic             rx_unf,
  output logic             flush_busy_err
);
  dfifo_core #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_tx_q (
    .clk(clk), .rst(rst), .en(tx_fifo_en), .flush(soft_rst),
    .push(tx_wr), .push_data(tx_wdata), .pop(tx_take), .pop_data(tx_word),
    .level(tx_level), .full(tx_full), .half(tx_half), .ovf(tx_ovf), .unf(tx_unf)
  );

  dfifo_core #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rx_q (
    .clk(clk), .rst(rst), .en(rx_fifo_en), .flush(soft_rst),
    .push(rx_put), .push_data(rx_word), .pop(rx_rd), .pop_data(rx_rdata),
    .level(rx_level), .full(rx_ready), .half(rx_half), .ovf(rx_ovf), .unf(rx_unf)
  );

  dfifo_flush_guard #(.LW(LW)) u_guard (
    .clk(clk), .rst(rst), .flush(soft_rst),
    .rx_level(rx_level), .rx_full(rx_ready), .busy_err(flush_busy_err)
  );
endmodule

// File: tb/dual_fifo_status_bench.sv
module dual_fifo_status_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, soft_rst, tx_fifo_en, rx_fifo_en;
  logic tx_wr, tx_take, rx_put, rx_rd;
  logic [8:0] tx_wdata, rx_word, tx_word, rx_rdata;
  logic [2:0] tx_level, rx_level;
  logic tx_half, tx_full, tx_ovf, tx_unf, rx_half, rx_ready, rx_ovf, rx_unf, flush_busy_err;

  int checks = 0;
  int fails = 0;

  dual_fifo_status u_dual_fifo_status (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .tx_fifo_en(tx_fifo_en), .rx_fifo_en(rx_fifo_en),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_take(tx_take), .tx_word(tx_word),
    .rx_put(rx_put), .rx_word(rx_word), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
    .tx_level(tx_level), .tx_half(tx_half), .tx_full(tx_full), .tx_ovf(tx_ovf), .tx_unf(tx_unf),
    .rx_level(rx_level), .rx_half(rx_half), .rx_ready(rx_ready), .rx_ovf(rx_ovf), .rx_unf(rx_unf),
    .flush_busy_err(flush_busy_err)
  );

  task automatic chkv(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit txw, input logic [8:0] txd, input bit txt,
                     input bit rxp, input logic [8:0] rxd, input bit rxr, input bit sr);
    tx_wr = txw; tx_wdata = txd; tx_take = txt;
    rx_put = rxp; rx_word = rxd; rx_rd = rxr; soft_rst = sr;
    @(posedge clk);
    #2;
    tx_wr = 0; tx_take = 0; rx_put = 0; rx_rd = 0; soft_rst = 0;
  endtask

  task automatic push(input int s, input logic [8:0] d);
    if (s == 0) cyc(1, d, 0, 0, 0, 0, 0);
    else        cyc(0, 0, 0, 1, d, 0, 0);
  endtask

  task automatic pop(input int s);
    if (s == 0) cyc(0, 0, 1, 0, 0, 0, 0);
    else        cyc(0, 0, 0, 0, 0, 1, 0);
  endtask

  task automatic flush();
    cyc(0, 0, 0, 0, 0, 0, 1);
  endtask

  function automatic int lvl(input int s);  return (s == 0) ? int'(tx_level) : int'(rx_level); endfunction
  function automatic int fl(input int s);   return (s == 0) ? int'(tx_full)  : int'(rx_ready); endfunction
  function automatic int hf(input int s);   return (s == 0) ? int'(tx_half)  : int'(rx_half);  endfunction
  function automatic int ov(input int s);   return (s == 0) ? int'(tx_ovf)   : int'(rx_ovf);   endfunction
  function automatic int un(input int s);   return (s == 0) ? int'(tx_unf)   : int'(rx_unf);   endfunction
  function automatic int rd(input int s);   return (s == 0) ? int'(tx_word)  : int'(rx_rdata); endfunction
  function automatic int wgen(input int s, input int n, input int k);
    return (s * 211 + n * 37 + k * 53 + 1) % 512;
  endfunction

  initial begin
    #(20 * 100000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1; soft_rst = 0; tx_fifo_en = 1; rx_fifo_en = 1;
    tx_wr = 0; tx_take = 0; rx_put = 0; rx_rd = 0; tx_wdata = 0; rx_word = 0;
    repeat (3) @(posedge clk);
    #2 rst = 0;

    // R1 reset state
    chkv("R1 tx_level", tx_level, 0);  chkv("R1 rx_level", rx_level, 0);
    chkv("R1 tx_full", tx_full, 0);    chkv("R1 rx_ready", rx_ready, 0);
    chkv("R1 tx_half", tx_half, 0);    chkv("R1 rx_half", rx_half, 0);
    chkv("R1 ovf/unf", tx_ovf | tx_unf | rx_ovf | rx_unf, 0);
    chkv("R1 busy_err", flush_busy_err, 0);

    // fill-depth sweep on both sides
    for (int s = 0; s < 2; s++) begin
      for (int n = 1; n <= 10; n++) begin
        int m;
        m = (n > 8) ? 8 : n;
        flush();
        chkv("R9 level after flush", lvl(s), 0);
        for (int k = 0; k < n; k++) begin
          int e;
          push(s, 9'(wgen(s, n, k)));
          e = (k + 1 > 8) ? 8 : k + 1;
          chkv("R2 level field", lvl(s), e % 8);
          chkv("R2 full/ready flag", fl(s), (e == 8) ? 1 : 0);
          chkv("R4 half flag", hf(s), (e >= 4) ? 1 : 0);
          chkv("R11 other side untouched", lvl(1 - s), 0);
        end
        chkv("R5 sticky overflow", ov(s), (n > 8) ? 1 : 0);
        for (int k = 0; k < m; k++) begin
          pop(s);
          if (s == 1 && k == 0) chkv("R11 first (echo) word kept", rd(s), wgen(s, n, k));
          else                  chkv("R3 order and data", rd(s), wgen(s, n, k));
          chkv("R2 level while draining", lvl(s), (m - k - 1) % 8);
        end
        pop(s);
        chkv("R6 data holds on empty pop", rd(s), wgen(s, n, m - 1));
        chkv("R6 underflow set", un(s), 1);
        chkv("R6 level stays 0", lvl(s), 0);
        chkv("R6 not full", fl(s), 0);
        flush();
        chkv("R9 stickies cleared", ov(s) + un(s), 0);
        chkv("R10 clean flush no error", flush_busy_err, 0);
      end
    end

    // R7 balanced push and pop
    flush();
    push(0, 9'h1A5); push(0, 9'h0C3); push(0, 9'h17E);
    cyc(1, 9'h111, 1, 0, 0, 0, 0);
    chkv("R7 level unchanged", tx_level, 3);
    chkv("R7 oldest word out", tx_word, 9'h1A5);

    // R8 disabled side ignores strobes
    tx_fifo_en = 0;
    push(0, 9'h055);
    pop(0);
    chkv("R8 tx level unchanged", tx_level, 3);
    chkv("R8 tx data unchanged", tx_word, 9'h1A5);
    chkv("R8 tx no stickies", tx_ovf + tx_unf, 0);
    tx_fifo_en = 1;
    pop(0); chkv("R8 tx contents intact", tx_word, 9'h0C3);
    pop(0); chkv("R7 order after balanced op", tx_word, 9'h17E);
    pop(0); chkv("R7 pushed word kept", tx_word, 9'h111);
    rx_fifo_en = 0;
    push(1, 9'h0AA);
    chkv("R8 rx level unchanged", rx_level, 0);
    chkv("R8 rx ready unchanged", rx_ready, 0);
    rx_fifo_en = 1;
    pop(1);
    chkv("R8 rx was empty", rx_unf, 1);

    // R9 flush overrides same-cycle push
    flush();
    push(0, 9'h001); push(0, 9'h002); push(0, 9'h003);
    cyc(1, 9'h004, 0, 1, 9'h005, 0, 1);
    chkv("R9 tx emptied over push", tx_level + tx_full, 0);
    chkv("R9 rx emptied over push", rx_level + rx_ready, 0);

    // R10 busy error on flush with unread receive words
    push(1, 9'h101); push(1, 9'h102);
    flush();
    chkv("R10 error on partial rx", flush_busy_err, 1);
    chkv("R9 rx emptied", rx_level, 0);
    flush();
    chkv("R10 clean flush clears", flush_busy_err, 0);
    for (int k = 0; k < 8; k++) push(1, 9'(k));
    chkv("R2 rx level reads 0 when full", rx_level, 0);
    chkv("R2 rx ready set when full", rx_ready, 1);
    flush();
    chkv("R10 error on full rx", flush_busy_err, 1);
    rst = 1;
    @(posedge clk);
    #2 rst = 0;
    chkv("R1 reset clears error", flush_busy_err, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule